// File: doc/BRIEF.md
# Interrupt Request Qualifier and Recognizer

This block watches a 3-bit encoded interrupt request level coming from outside the chip and decides when the processor should take an interrupt. The level is sampled on every falling edge of the system clock. A new level counts only once two samples in a row agree, so a request that lasts a single sample is dropped. The qualified level is then compared with the current priority mask. A request above the mask is reported as pending. A request at or below the mask is not stored anywhere.

Pending priority is never latched. At each rising edge the block looks at the live qualified level, so if a higher request replaces a lower one, the higher one is serviced. If the request is withdrawn before it is taken, it is simply gone.

The core raises a boundary strobe at instruction boundaries, and also when a higher-priority exception finishes. When that strobe meets a pending request, the block does two things:
- It emits a one-clock take pulse carrying the level to acknowledge.
- It copies that level into the mask, so lower requests stay blocked while the interrupt is serviced.

Level 7 cannot be masked, but only a transition into level 7 counts. A level 7 held steady is taken once. Software can also load the mask directly, for example on return from an exception.

Top module: `irq_recognizer`

## Requirements
- R1: While reset is high and after it is released, the mask reads 7, `pend_o` is 0, `pend_lvl_o` is 0, `take_o` is 0 and `take_lvl_o` is 0.
- R2: `irq_lvl_i` is sampled on falling clock edges. A value becomes the qualified level only at a falling edge where it equals the previous sample. A value present for a single sample never becomes pending.
- R3: Level code 0 means no request. `pend_o` is 1 exactly when the qualified level is above the mask (or the level-7 rule of R8 applies). `pend_lvl_o` then equals the qualified level; otherwise it is 0.
- R4: A qualified level at or below the mask (other than the level-7 case) gives no pending indication and no take. Lowering the mask after that request has been withdrawn produces no pending state and no take.
- R5: The pending level follows the live qualified level without storage. A higher level replaces a lower one, and a lower level replaces a higher one, as long as it stays above the mask.
- R6: `take_o` is high for one clock after a rising edge at which `bnd_i` was 1 and a request was pending. `take_lvl_o` then carries the pending level. With `bnd_i` at 0 no take occurs, and when no take occurs `take_lvl_o` is 0.
- R7: At a take, the mask becomes the acknowledged level, so a request at that level held steady gives no second take.
- R8: Level 7 is pending even when the mask is 7, but only after the qualified level changed to 7 from a lower value. Once taken, a steady level 7 is not taken again until it has left 7 and returned.
- R9: `mask_ld_i` loads `mask_i` into the mask at the rising edge. If a take happens at the same edge, the taken level is written instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; requests sampled on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_lvl_i | input | 3 | Encoded request level, 0 = none, active high |
| bnd_i | input | 1 | Instruction-boundary / exception-done strobe |
| mask_ld_i | input | 1 | Load strobe for the mask |
| mask_i | input | 3 | Mask value to load |
| pend_o | output | 1 | A request above the mask is pending |
| pend_lvl_o | output | 3 | Pending level, 0 when none |
| take_o | output | 1 | One-clock take-interrupt pulse |
| take_lvl_o | output | 3 | Level being acknowledged |
| mask_o | output | 3 | Current priority mask |

## Verification
Directed sequences cover several cases, each separating one behaviour from a nearby wrong one:
- A one-sample glitch, which separates real two-sample qualification from single-sample capture.
- A request equal to the mask that is later withdrawn, which separates "no trace" from a latched request.
- A rising and then a falling pending level, which separates live priority from stored priority.
- A held level 7 at mask 7, which separates edge-only recognition of the non-maskable level from level recognition.
- A take and a mask load at the same edge, which shows the write priority.

A seeded random phase then drives levels that change often and include one-cycle pulses, together with random boundary strobes and mask loads. Every cycle it compares all outputs against a reference model built from the requirements.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;

    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_NONE = '0;
    localparam lvl_t LVL_TOP  = '1;

    typedef struct packed {
        logic valid;
        lvl_t lvl;
    } pend_t;

    function automatic logic beats_mask(input lvl_t lvl, input lvl_t mask);
        return lvl > mask;
    endfunction

endpackage

// File: rtl/irq_lvl_filter.sv
module irq_lvl_filter
    import irq_rec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  lvl_t lvl_i,
    output lvl_t qual_o
);
    lvl_t smp_q;
    lvl_t qual_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            smp_q  <= LVL_NONE;
            qual_q <= LVL_NONE;
        end else begin
            smp_q <= lvl_i;
            if (lvl_i == smp_q)
                qual_q <= lvl_i;
        end
    end

    assign qual_o = qual_q;

    AST_QUAL_TWO_SAMPLES: assert property (@(negedge clk) disable iff (rst)
        !$stable(qual_q) |-> (qual_q == $past(smp_q)) && (qual_q == smp_q)) // R2
        else $error("qualified level changed without two equal samples");

endmodule

// File: rtl/irq_pend_eval.sv
module irq_pend_eval
    import irq_rec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lvl_t  qual_i,
    input  lvl_t  mask_i,
    input  logic  take_i,
    output pend_t pend_o
);
    lvl_t qual_d_q;
    logic nmi_q;
    logic nmi_edge;
    logic nmi_live;
    logic valid;

    always_comb begin
        nmi_edge = (qual_i == LVL_TOP) && (qual_d_q != LVL_TOP);
        nmi_live = (qual_i == LVL_TOP) && (nmi_q || nmi_edge);
        valid    = beats_mask(qual_i, mask_i) || nmi_live;
        pend_o.valid = valid;
        pend_o.lvl   = valid ? qual_i : LVL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qual_d_q <= LVL_NONE;
            nmi_q    <= 1'b0;
        end else begin
            qual_d_q <= qual_i;
            nmi_q    <= nmi_live && !take_i;
        end
    end

    AST_NMI_TAKEN_ONCE: assert property (@(posedge clk) disable iff (rst)
        ($past(take_i) && ($past(qual_i) == LVL_TOP) && (qual_i == LVL_TOP)
         && (mask_i == LVL_TOP)) |-> !pend_o.valid) // R8
        else $error("steady top level recognized twice");

    AST_PEND_LVL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (qual_i == LVL_NONE) |-> !pend_o.valid) // R3
        else $error("level zero reported pending");

endmodule

// File: rtl/irq_take_ctrl.sv
module irq_take_ctrl
    import irq_rec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bnd_i,
    input  pend_t pend_i,
    input  logic  mask_ld_i,
    input  lvl_t  mask_i,
    output logic  take_now_o,
    output logic  take_o,
    output lvl_t  take_lvl_o,
    output lvl_t  mask_o
);
    logic take_q;
    lvl_t take_lvl_q;
    lvl_t mask_q;

    assign take_now_o = bnd_i && pend_i.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q     <= 1'b0;
            take_lvl_q <= LVL_NONE;
            mask_q     <= LVL_TOP;
        end else begin
            take_q     <= take_now_o;
            take_lvl_q <= take_now_o ? pend_i.lvl : LVL_NONE;
            if (take_now_o)
                mask_q <= pend_i.lvl;
            else if (mask_ld_i)
                mask_q <= mask_i;
        end
    end

    assign take_o     = take_q;
    assign take_lvl_o = take_lvl_q;
    assign mask_o     = mask_q;

    AST_TAKE_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        take_q |-> $past(bnd_i)) // R6
        else $error("take without boundary strobe");

    AST_TAKE_LVL_NONZERO: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (take_lvl_q != LVL_NONE)) // R6
        else $error("take of level zero");

    AST_MASK_TRACKS_TAKE: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (mask_q == take_lvl_q)) // R7
        else $error("mask not updated to taken level");

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!$past(take_now_o) && $past(mask_ld_i) && !$past(rst)) |-> (mask_q == $past(mask_i))) // R9
        else $error("mask load lost");

endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
    import irq_rec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] irq_lvl_i,
    input  logic       bnd_i,
    input  logic       mask_ld_i,
    input  logic [2:0] mask_i,
    output logic       pend_o,
    output logic [2:0] pend_lvl_o,
    output logic       take_o,
    output logic [2:0] take_lvl_o,
    output logic [2:0] mask_o
);
    lvl_t  qual;
    lvl_t  mask_cur;
    pend_t pend;
    logic  take_now;

    irq_lvl_filter u_filter (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (irq_lvl_i),
        .qual_o (qual)
    );

    irq_pend_eval u_pend (
        .clk    (clk),
        .rst    (rst),
        .qual_i (qual),
        .mask_i (mask_cur),
        .take_i (take_now),
        .pend_o (pend)
    );

    irq_take_ctrl u_take (
        .clk        (clk),
        .rst        (rst),
        .bnd_i      (bnd_i),
        .pend_i     (pend),
        .mask_ld_i  (mask_ld_i),
        .mask_i     (mask_i),
        .take_now_o (take_now),
        .take_o     (take_o),
        .take_lvl_o (take_lvl_o),
        .mask_o     (mask_cur)
    );

    assign pend_o     = pend.valid;
    assign pend_lvl_o = pend.lvl;
    assign mask_o     = mask_cur;

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!take_o && (mask_o == LVL_TOP))) // R1
        else $error("state after reset wrong");

endmodule

// File: tb/irq_recognizer_tb.sv
module irq_recognizer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] irq_lvl = '0;
    logic       bnd = 1'b0;
    logic       mask_ld = 1'b0;
    logic [2:0] mask_in = '0;
    logic       pend_o;
    logic [2:0] pend_lvl_o;
    logic       take_o;
    logic [2:0] take_lvl_o;
    logic [2:0] mask_o;

    int errors = 0;
    int checks = 0;
    bit model_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_recognizer dut_i (
        .clk        (clk),
        .rst        (rst),
        .irq_lvl_i  (irq_lvl),
        .bnd_i      (bnd),
        .mask_ld_i  (mask_ld),
        .mask_i     (mask_in),
        .pend_o     (pend_o),
        .pend_lvl_o (pend_lvl_o),
        .take_o     (take_o),
        .take_lvl_o (take_lvl_o),
        .mask_o     (mask_o)
    );

    // reference model derived from the requirements
    logic [2:0] m_smp = '0, m_qual = '0, m_qd = '0, m_mask = 3'd7, m_tl = '0;
    logic       m_nmi = 1'b0, m_take = 1'b0;

    function automatic logic m_pend(input logic [2:0] q, input logic [2:0] mk,
                                    input logic [2:0] qd, input logic nmi);
        return (q > mk) || ((q == 3'd7) && (nmi || (qd != 3'd7)));
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            m_smp = '0; m_qual = '0;
        end else begin
            if (irq_lvl == m_smp) m_qual = irq_lvl;
            m_smp = irq_lvl;
        end
    end

    always @(posedge clk) begin
        logic p;
        logic tk;
        p  = m_pend(m_qual, m_mask, m_qd, m_nmi);
        tk = bnd && p;
        if (rst) begin
            m_mask = 3'd7; m_take = 1'b0; m_tl = '0; m_qd = '0; m_nmi = 1'b0;
        end else begin
            m_nmi  = (m_qual == 3'd7) && (m_nmi || (m_qd != 3'd7)) && !tk;
            m_qd   = m_qual;
            m_take = tk;
            m_tl   = tk ? m_qual : 3'd0;
            if (tk) m_mask = m_qual;
            else if (mask_ld) m_mask = mask_in;
        end
    end

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #3;
        if (model_on && !rst) begin
            logic p;
            p = m_pend(m_qual, m_mask, m_qd, m_nmi);
            chk("R3", "model pend", pend_o, p);
            chk("R5", "model pend_lvl", pend_lvl_o, p ? m_qual : 0);
            chk("R6", "model take", {take_o, take_lvl_o}, {m_take, m_tl});
            chk("R7", "model mask", mask_o, m_mask);
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        step(3);
        // R1 reset state while in reset
        chk("R1", "mask in reset", mask_o, 7);
        chk("R1", "pend in reset", pend_o, 0);
        rst = 1'b0;
        step(1);
        chk("R1", "mask after reset", mask_o, 7);
        chk("R1", "take after reset", take_o, 0);
        chk("R1", "take_lvl after reset", take_lvl_o, 0);
        chk("R1", "pend_lvl after reset", pend_lvl_o, 0);
        model_on = 1'b1;

        // R9 mask load
        mask_ld = 1'b1; mask_in = 3'd2; step(1); mask_ld = 1'b0;
        chk("R9", "mask loaded", mask_o, 2);

        // R2 single-sample glitch
        irq_lvl = 3'd5; step(1);
        chk("R2", "glitch first sample", pend_o, 0);
        irq_lvl = 3'd0; step(1);
        chk("R2", "glitch gone", pend_o, 0);
        step(2);
        chk("R2", "glitch never pending", pend_lvl_o, 0);

        // R4 equal to mask ignored, no trace
        irq_lvl = 3'd2; step(3);
        chk("R4", "equal to mask", pend_o, 0);
        irq_lvl = 3'd0; step(3);
        mask_ld = 1'b1; mask_in = 3'd1; step(1); mask_ld = 1'b0;
        bnd = 1'b1; step(1);
        chk("R4", "no trace pend", pend_o, 0);
        step(1); bnd = 1'b0;
        chk("R4", "no trace take", take_o, 0);

        // R3 / R5 live priority
        irq_lvl = 3'd3; step(3);
        chk("R3", "pend lvl 3", pend_lvl_o, 3);
        irq_lvl = 3'd5; step(3);
        chk("R5", "higher replaces", pend_lvl_o, 5);
        irq_lvl = 3'd4; step(3);
        chk("R5", "lower replaces", pend_lvl_o, 4);
        chk("R6", "no take without boundary", take_o, 0);

        // R6 / R7 take
        bnd = 1'b1; step(1);
        chk("R6", "take pulse", take_o, 1);
        chk("R6", "take lvl", take_lvl_o, 4);
        chk("R7", "mask set to taken", mask_o, 4);
        step(1);
        chk("R6", "pulse one clock", take_o, 0);
        chk("R7", "held level blocked", pend_o, 0);
        bnd = 1'b0; irq_lvl = 3'd0; step(3);

        // R8 level 7 edge at mask 7
        mask_ld = 1'b1; mask_in = 3'd7; step(1); mask_ld = 1'b0;
        irq_lvl = 3'd7; step(3);
        chk("R8", "top level pending at mask 7", pend_o, 1);
        bnd = 1'b1; step(1);
        chk("R8", "top level taken", take_lvl_o, 7);
        step(1);
        chk("R8", "steady top not retaken", take_o, 0);
        chk("R8", "steady top not pending", pend_o, 0);
        bnd = 1'b0; irq_lvl = 3'd0; step(3);
        irq_lvl = 3'd7; step(3);
        chk("R8", "top re-armed after leaving", pend_o, 1);

        // R9 take wins over load at same edge
        bnd = 1'b1; mask_ld = 1'b1; mask_in = 3'd0; step(1);
        bnd = 1'b0; mask_ld = 1'b0;
        chk("R9", "take wins over load", mask_o, 7);
        chk("R9", "take happened", take_o, 1);
        irq_lvl = 3'd0; step(3);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(3) == 0) irq_lvl = 3'($urandom_range(7));
            bnd     = ($urandom_range(2) == 0);
            mask_ld = ($urandom_range(15) == 0);
            mask_in = 3'($urandom_range(7));
            step(1);
        end
        bnd = 1'b0; mask_ld = 1'b0;
        step(2);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule